// File: doc/BRIEF.md
# Dual-Mode FIFO with Programmable Almost Flags

A single-clock, 36-bit-wide first-in first-out buffer built on a small inferred RAM with a parameterised, power-of-two depth. At master reset it latches one of two read-timing modes. In standard mode a read request moves the oldest word onto the output register. The two status outputs then mean "not empty" and "not full". In first-word-fall-through mode the oldest word moves onto the output by itself. It stays there until a read consumes it, and the same two outputs then mean "output ready" and "input ready".

Two further outputs warn of an almost-empty and an almost-full level. Their thresholds come from one of five built-in values chosen at master reset. As an alternative they can be loaded after master reset, either one bit at a time on a serial pair of pins or as two words on the data bus. A partial reset empties the buffer but keeps the mode and the thresholds. A retransmit request rewinds reading to the first word written since the last reset, so that data already read is delivered again.

Top module: `dmf_top`

## Requirements
- R1: After a master reset with threshold code 0 in standard mode, `avail` is 0, `space` is 1, `alm_empty` is 1, `alm_full` is 0 and `dout` is 0.
- R2: `fwft_sel` is taken only while `mrst_n` is low (1 = fall-through, 0 = standard). A partial reset leaves the mode unchanged.
- R3: In standard mode, a clock edge with `rd_en` high and `avail` high places the oldest word on `dout`, in write order. A read while `avail` is low changes neither `dout` nor the stored data.
- R4: In fall-through mode, `avail` stays 0 right after the edge that writes into an empty buffer, and rises with the word on `dout` at the next edge. `dout` and `avail` hold until an edge with `rd_en` high.
- R5: The buffer holds at most DEPTH words in RAM, and `space` is 0 when it is full. A write while `space` is 0 is dropped.
- R6: A read and a write accepted on the same edge both take effect, and the word count is unchanged.
- R7: The threshold codes on `off_sel` (sampled while `mrst_n` is low) are 0→8, 1→16, 2→64, 3→256 and 4→1024. The same value is used for both flags.
- R8: `alm_empty` is 1 when the words held (including a word waiting on `dout` in fall-through mode) are at or below the empty threshold. `alm_full` is 1 when the free RAM entries are at or below the full threshold.
- R9: With `off_sel`=5, after master reset `space` is 0. The first write loads the empty threshold from `din[10:0]` and the second loads the full threshold. Neither write enters the buffer, and `space` then becomes 1.
- R10: With `off_sel`=6 or 7, each edge with `ser_en` high shifts in `ser_d`. After 22 bits, the first 11 bits (MSB first) become the empty threshold and the last 11 the full threshold. Until then `space` is 0 and writes are dropped.
- R11: A partial reset (`prst_n` low) empties the buffer but keeps the loaded thresholds and their loaded state.
- R12: A retransmit pulse rewinds reading to the first word written since the last reset. The held count becomes the number of words written since then, for at most DEPTH writes. A read or write on that same edge is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mrst_n | input | 1 | Synchronous master reset: empties buffer, loads mode and thresholds |
| prst_n | input | 1 | Synchronous partial reset: empties buffer only |
| fwft_sel | input | 1 | Read-timing mode, sampled during master reset |
| off_sel | input | 3 | Threshold code, sampled during master reset |
| ser_d | input | 1 | Serial threshold data |
| ser_en | input | 1 | Serial threshold shift enable |
| wr_en | input | 1 | Write request |
| din | input | 36 | Write data / parallel threshold value |
| rd_en | input | 1 | Read request |
| rt | input | 1 | Retransmit request |
| dout | output | 36 | Output word register |
| avail | output | 1 | Not-empty (standard) or output-ready (fall-through) |
| space | output | 1 | Not-full (standard) or input-ready (fall-through) |
| alm_empty | output | 1 | Almost-empty flag |
| alm_full | output | 1 | Almost-full flag |

## Verification
On every cycle the assertions check that the count never exceeds the depth, and that a full buffer stays full without a read. They also check that a paired read and write leaves the count alone, that a waiting fall-through word holds steady, that a retransmit lands on the rewound pointer, and that mode and loaded state survive everything but master reset. The bench scenarios are the only way to show the data order, the threshold values that each code or load sequence gives, the boundary where each almost flag switches, and the replay of data after a rewind.

// File: rtl/dmf_pkg.sv
package dmf_pkg;

  localparam int OFF_W = 11;

  typedef enum logic [1:0] {
    LD_DFLT = 2'd0,
    LD_PAR  = 2'd1,
    LD_SER  = 2'd2
  } ld_mode_e;

  function automatic logic [OFF_W-1:0] dflt_off(input logic [2:0] code);
    logic [OFF_W-1:0] v;
    case (code)
      3'd0:    v = OFF_W'(8);
      3'd1:    v = OFF_W'(16);
      3'd2:    v = OFF_W'(64);
      3'd3:    v = OFF_W'(256);
      default: v = OFF_W'(1024);
    endcase
    return v;
  endfunction

endpackage

// File: rtl/dmf_cfg.sv
module dmf_cfg
  import dmf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mrst_n,
  input  logic             fwft_sel,
  input  logic [2:0]       off_sel,
  input  logic             ser_d,
  input  logic             ser_en,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] din_off,
  output logic             fwft,
  output logic             done,
  output logic [OFF_W-1:0] ae_off,
  output logic [OFF_W-1:0] af_off
);

  localparam int SH_W  = 2 * OFF_W;
  localparam int SBW   = $clog2(SH_W);

  logic             fwft_q, fwft_d;
  logic             done_q, done_d;
  logic             pidx_q, pidx_d;
  ld_mode_e         how_q, how_d;
  logic [SBW-1:0]   nbit_q, nbit_d;
  logic [SH_W-2:0]  sh_q, sh_d;
  logic [OFF_W-1:0] ae_q, ae_d, af_q, af_d;
  logic [SH_W-1:0]  sh_full;

  always_comb begin
    fwft_d  = fwft_q;
    done_d  = done_q;
    pidx_d  = pidx_q;
    how_d   = how_q;
    nbit_d  = nbit_q;
    sh_d    = sh_q;
    ae_d    = ae_q;
    af_d    = af_q;
    sh_full = {sh_q, ser_d};
    if (!mrst_n) begin
      fwft_d = fwft_sel;
      pidx_d = 1'b0;
      nbit_d = '0;
      sh_d   = '0;
      if (off_sel <= 3'd4) begin
        how_d  = LD_DFLT;
        done_d = 1'b1;
        ae_d   = dflt_off(off_sel);
        af_d   = dflt_off(off_sel);
      end else begin
        how_d  = (off_sel == 3'd5) ? LD_PAR : LD_SER;
        done_d = 1'b0;
        ae_d   = '0;
        af_d   = '0;
      end
    end else if (!done_q) begin
      if (how_q == LD_PAR && wr_en) begin
        if (pidx_q) begin
          af_d   = din_off;
          done_d = 1'b1;
        end else begin
          ae_d   = din_off;
          pidx_d = 1'b1;
        end
      end else if (how_q == LD_SER && ser_en) begin
        sh_d   = sh_full[SH_W-2:0];
        nbit_d = nbit_q + SBW'(1);
        if (nbit_q == SBW'(SH_W - 1)) begin
          ae_d   = sh_full[SH_W-1:OFF_W];
          af_d   = sh_full[OFF_W-1:0];
          done_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwft_q <= 1'b0;
      done_q <= 1'b0;
      pidx_q <= 1'b0;
      how_q  <= LD_DFLT;
      nbit_q <= '0;
      sh_q   <= '0;
      ae_q   <= '0;
      af_q   <= '0;
    end else begin
      fwft_q <= fwft_d;
      done_q <= done_d;
      pidx_q <= pidx_d;
      how_q  <= how_d;
      nbit_q <= nbit_d;
      sh_q   <= sh_d;
      ae_q   <= ae_d;
      af_q   <= af_d;
    end
  end

  assign fwft   = fwft_q;
  assign done   = done_q;
  assign ae_off = ae_q;
  assign af_off = af_q;

  // R2: mode changes only under master reset
  p_mode_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mrst_n |=> $stable(fwft_q));

  // R9 / R10: once loaded, thresholds stay loaded until master reset
  p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mrst_n && done_q) |=> done_q);

  p_off_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mrst_n && done_q) |=> ($stable(ae_q) && $stable(af_q)));

endmodule

// File: rtl/dmf_core.sv
module dmf_core #(
  parameter int DW    = 36,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          fwft,
  input  logic          wr_req,
  input  logic [DW-1:0] din,
  input  logic          rd_en,
  input  logic          rt,
  output logic [DW-1:0] dout,
  output logic          ov,
  output logic [CW-1:0] mcnt
);

  logic [DW-1:0] mem [DEPTH];

  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] mcnt_q, mcnt_d, wcnt_q, wcnt_d;
  logic          ov_q, ov_d;
  logic [DW-1:0] dout_q, dout_d;
  logic          wr_ok, rd_std, ld_fw, mem_rd;

  always_comb begin
    wr_ok  = wr_req && (mcnt_q != CW'(DEPTH));
    rd_std = !fwft && rd_en && (mcnt_q != '0);
    ld_fw  = fwft && (mcnt_q != '0) && (!ov_q || rd_en);
    mem_rd = rd_std || ld_fw;

    wptr_d = wptr_q;
    rptr_d = rptr_q;
    mcnt_d = mcnt_q;
    wcnt_d = wcnt_q;
    ov_d   = ov_q;
    dout_d = dout_q;

    if (clear) begin
      wptr_d = '0;
      rptr_d = '0;
      mcnt_d = '0;
      wcnt_d = '0;
      ov_d   = 1'b0;
      dout_d = '0;
    end else if (rt) begin
      rptr_d = '0;
      mcnt_d = wcnt_q;
      ov_d   = 1'b0;
    end else begin
      if (wr_ok) begin
        wptr_d = wptr_q + AW'(1);
        if (wcnt_q != CW'(DEPTH)) wcnt_d = wcnt_q + CW'(1);
      end
      if (mem_rd) begin
        rptr_d = rptr_q + AW'(1);
        dout_d = mem[rptr_q];
      end
      mcnt_d = mcnt_q + CW'(wr_ok) - CW'(mem_rd);
      if (ld_fw)             ov_d = 1'b1;
      else if (fwft && rd_en) ov_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok && !clear && !rt) mem[wptr_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      mcnt_q <= '0;
      wcnt_q <= '0;
      ov_q   <= 1'b0;
      dout_q <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      mcnt_q <= mcnt_d;
      wcnt_q <= wcnt_d;
      ov_q   <= ov_d;
      dout_q <= dout_d;
    end
  end

  assign dout = dout_q;
  assign ov   = ov_q;
  assign mcnt = mcnt_q;

  // R5: count bounded by the depth
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mcnt_q <= CW'(DEPTH));

  // R5: a full RAM with nothing leaving stays full
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !rt && mcnt_q == CW'(DEPTH) && !mem_rd) |=> mcnt_q == CW'(DEPTH));

  // R6: paired read and write keep the count
  p_rw_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !rt && wr_ok && mem_rd) |=> mcnt_q == $past(mcnt_q));

  // R4: waiting fall-through word holds without a read
  p_fw_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !rt && fwft && ov_q && !rd_en) |=> (ov_q && $stable(dout_q)));

  // R12: retransmit lands on the start with the written count
  p_rt_rewind_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && rt) |=> (rptr_q == '0 && mcnt_q == $past(wcnt_q) && !ov_q));

endmodule

// File: rtl/dmf_flags.sv
module dmf_flags
  import dmf_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH) + 1,
  localparam int XW   = ((CW > OFF_W) ? CW : OFF_W) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fwft,
  input  logic             done,
  input  logic [CW-1:0]    mcnt,
  input  logic             ov,
  input  logic [OFF_W-1:0] ae_off,
  input  logic [OFF_W-1:0] af_off,
  output logic             avail,
  output logic             space,
  output logic             alm_empty,
  output logic             alm_full
);

  logic [XW-1:0] held, room;

  always_comb begin
    held      = XW'(mcnt) + XW'(fwft & ov);
    room      = XW'(DEPTH) - XW'(mcnt);
    avail     = fwft ? ov : (mcnt != '0);
    space     = done && (mcnt != CW'(DEPTH));
    alm_empty = held <= XW'(ae_off);
    alm_full  = room <= XW'(af_off);
  end

  // R8: a full RAM always reports almost-full
  p_full_af_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mcnt == CW'(DEPTH)) |-> alm_full);

  // R8: nothing available in standard mode implies almost-empty
  p_empty_ae_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fwft && !avail) |-> alm_empty);

endmodule

// File: rtl/dmf_top.sv
module dmf_top
  import dmf_pkg::*;
#(
  parameter int DW    = 36,
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          fwft_sel,
  input  logic [2:0]    off_sel,
  input  logic          ser_d,
  input  logic          ser_en,
  input  logic          wr_en,
  input  logic [DW-1:0] din,
  input  logic          rd_en,
  input  logic          rt,
  output logic [DW-1:0] dout,
  output logic          avail,
  output logic          space,
  output logic          alm_empty,
  output logic          alm_full
);

  logic [1:0]       rsync_q;
  logic             rst_s_n;
  logic             fwft, done, ov, clear;
  logic [OFF_W-1:0] ae_off, af_off;
  logic [CW-1:0]    mcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  assign clear = !mrst_n || !prst_n;

  dmf_cfg u_cfg (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .mrst_n   (mrst_n),
    .fwft_sel (fwft_sel),
    .off_sel  (off_sel),
    .ser_d    (ser_d),
    .ser_en   (ser_en),
    .wr_en    (wr_en),
    .din_off  (din[OFF_W-1:0]),
    .fwft     (fwft),
    .done     (done),
    .ae_off   (ae_off),
    .af_off   (af_off)
  );

  dmf_core #(.DW(DW), .DEPTH(DEPTH)) u_core (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .clear  (clear),
    .fwft   (fwft),
    .wr_req (wr_en && done),
    .din    (din),
    .rd_en  (rd_en),
    .rt     (rt),
    .dout   (dout),
    .ov     (ov),
    .mcnt   (mcnt)
  );

  dmf_flags #(.DEPTH(DEPTH)) u_flags (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .fwft      (fwft),
    .done      (done),
    .mcnt      (mcnt),
    .ov        (ov),
    .ae_off    (ae_off),
    .af_off    (af_off),
    .avail     (avail),
    .space     (space),
    .alm_empty (alm_empty),
    .alm_full  (alm_full)
  );

endmodule

// File: tb/dmf_top_bench.sv
`timescale 1ns/1ps
module dmf_top_bench;

  logic        clk = 1'b0;
  logic        rst_n, mrst_n, prst_n, fwft_sel, ser_d, ser_en, wr_en, rd_en, rt;
  logic [2:0]  off_sel;
  logic [35:0] din, dout;
  logic        avail, space, alm_empty, alm_full;

  int n_chk = 0;
  int n_bad = 0;
  logic [35:0] q[$];
  logic [35:0] hist[$];

  always #2 clk = ~clk;

  dmf_top u_dmf_top (
    .clk(clk), .rst_n(rst_n), .mrst_n(mrst_n), .prst_n(prst_n),
    .fwft_sel(fwft_sel), .off_sel(off_sel), .ser_d(ser_d), .ser_en(ser_en),
    .wr_en(wr_en), .din(din), .rd_en(rd_en), .rt(rt), .dout(dout),
    .avail(avail), .space(space), .alm_empty(alm_empty), .alm_full(alm_full)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [35:0] d);
    logic acc;
    acc = space;
    wr_en = 1'b1; din = d;
    tick();
    wr_en = 1'b0;
    if (acc) begin q.push_back(d); hist.push_back(d); end
  endtask

  task automatic fill_to(input int n);
    while (q.size() < n) wr(36'h100 + 36'(hist.size()));
  endtask

  task automatic rd_std(input string req);
    logic [35:0] e;
    e = q.pop_front();
    rd_en = 1'b1;
    tick();
    rd_en = 1'b0;
    chk(req, dout, e);
  endtask

  task automatic do_mrst(input logic f, input logic [2:0] s);
    mrst_n = 1'b0; fwft_sel = f; off_sel = s;
    tick(); tick();
    mrst_n = 1'b1;
    q.delete(); hist.delete();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; mrst_n = 1'b0; prst_n = 1'b1; fwft_sel = 1'b0; off_sel = 3'd0;
    ser_d = 1'b0; ser_en = 1'b0; wr_en = 1'b0; rd_en = 1'b0; rt = 1'b0; din = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    mrst_n = 1'b1;
    tick();
    chk("R1 avail", 36'(avail), 36'd0);
    chk("R1 space", 36'(space), 36'd1);
    chk("R1 alm_empty", 36'(alm_empty), 36'd1);
    chk("R1 alm_full", 36'(alm_full), 36'd0);
    chk("R1 dout", dout, 36'd0);
  endtask

  task automatic t_std_flags();
    logic [35:0] e, keep;
    do_mrst(1'b0, 3'd0);
    fill_to(8);
    chk("R8 ae at 8", 36'(alm_empty), 36'd1);
    fill_to(9);
    chk("R8 ae at 9", 36'(alm_empty), 36'd0);
    chk("R3 avail", 36'(avail), 36'd1);
    // R6: paired read and write
    e = q.pop_front();
    q.push_back(36'hABC); hist.push_back(36'hABC);
    rd_en = 1'b1; wr_en = 1'b1; din = 36'hABC;
    tick();
    rd_en = 1'b0; wr_en = 1'b0;
    chk("R6 read data", dout, e);
    chk("R6 count kept", 36'(alm_empty), 36'd0);
    rd_std("R3 order");
    chk("R6 count after read", 36'(alm_empty), 36'd1);
    fill_to(55);
    chk("R8 af at 55", 36'(alm_full), 36'd0);
    fill_to(56);
    chk("R8 af at 56", 36'(alm_full), 36'd1);
    fill_to(64);
    chk("R5 space full", 36'(space), 36'd0);
    wr(36'hBAD);
    chk("R5 still full", 36'(space), 36'd0);
    while (q.size() > 0) rd_std("R5 R3 drain");
    chk("R5 empty after 64", 36'(avail), 36'd0);
    keep = dout;
    rd_en = 1'b1; tick(); rd_en = 1'b0;
    chk("R3 empty read", dout, keep);
    chk("R3 empty read avail", 36'(avail), 36'd0);
  endtask

  task automatic t_defaults();
    do_mrst(1'b0, 3'd1);
    chk("R7 code1 af empty", 36'(alm_full), 36'd0);
    fill_to(16);
    chk("R7 code1 ae 16", 36'(alm_empty), 36'd1);
    fill_to(17);
    chk("R7 code1 ae 17", 36'(alm_empty), 36'd0);
    fill_to(47);
    chk("R7 code1 af 47", 36'(alm_full), 36'd0);
    fill_to(48);
    chk("R7 code1 af 48", 36'(alm_full), 36'd1);
    do_mrst(1'b0, 3'd2);
    chk("R7 code2 af", 36'(alm_full), 36'd1);
    fill_to(50);
    chk("R7 code2 ae 50", 36'(alm_empty), 36'd1);
    do_mrst(1'b0, 3'd3);
    chk("R7 code3 af", 36'(alm_full), 36'd1);
    do_mrst(1'b0, 3'd4);
    chk("R7 code4 af", 36'(alm_full), 36'd1);
  endtask

  task automatic t_fwft();
    do_mrst(1'b1, 3'd0);
    wr(36'hA1);
    chk("R4 not yet ready", 36'(avail), 36'd0);
    tick();
    chk("R4 ready", 36'(avail), 36'd1);
    chk("R4 head word", dout, 36'hA1);
    repeat (3) tick();
    chk("R4 hold", dout, 36'hA1);
    wr(36'hB2); wr(36'hC3);
    chk("R4 hold after writes", dout, 36'hA1);
    rd_en = 1'b1; tick(); rd_en = 1'b0;
    chk("R4 next word", dout, 36'hB2);
    rd_en = 1'b1; tick(); rd_en = 1'b0;
    chk("R4 third word", dout, 36'hC3);
    chk("R4 still ready", 36'(avail), 36'd1);
    rd_en = 1'b1; tick(); rd_en = 1'b0;
    chk("R4 drained", 36'(avail), 36'd0);
    // R11 / R2: partial reset keeps fall-through mode
    wr(36'hD4); wr(36'hE5); tick();
    prst_n = 1'b0; tick(); prst_n = 1'b1;
    q.delete(); hist.delete();
    chk("R11 emptied", 36'(avail), 36'd0);
    wr(36'hF6);
    chk("R2 mode kept wait", 36'(avail), 36'd0);
    tick();
    chk("R2 mode kept ready", 36'(avail), 36'd1);
    chk("R2 mode kept word", dout, 36'hF6);
  endtask

  task automatic t_parallel();
    do_mrst(1'b0, 3'd5);
    chk("R9 space while loading", 36'(space), 36'd0);
    wr(36'd3);
    chk("R9 space after one", 36'(space), 36'd0);
    wr(36'd5);
    chk("R9 space loaded", 36'(space), 36'd1);
    chk("R9 loads not stored", 36'(avail), 36'd0);
    fill_to(3);
    chk("R9 ae 3", 36'(alm_empty), 36'd1);
    fill_to(4);
    chk("R9 ae 4", 36'(alm_empty), 36'd0);
    fill_to(58);
    chk("R9 af 58", 36'(alm_full), 36'd0);
    fill_to(59);
    chk("R9 af 59", 36'(alm_full), 36'd1);
    prst_n = 1'b0; tick(); prst_n = 1'b1;
    q.delete(); hist.delete();
    chk("R11 space kept", 36'(space), 36'd1);
    chk("R11 empty", 36'(avail), 36'd0);
    fill_to(3);
    chk("R11 ae kept 3", 36'(alm_empty), 36'd1);
    fill_to(4);
    chk("R11 ae kept 4", 36'(alm_empty), 36'd0);
  endtask

  task automatic t_serial();
    logic [21:0] bits;
    do_mrst(1'b0, 3'd6);
    chk("R10 space while loading", 36'(space), 36'd0);
    wr(36'h77);
    bits = {11'd2, 11'd10};
    for (int i = 21; i >= 0; i--) begin
      ser_d = bits[i]; ser_en = 1'b1;
      if (i == 1) begin
        chk("R10 space before last bit", 36'(space), 36'd0);
      end
      tick();
    end
    ser_en = 1'b0;
    chk("R10 space loaded", 36'(space), 36'd1);
    chk("R10 write dropped", 36'(avail), 36'd0);
    fill_to(2);
    chk("R10 ae 2", 36'(alm_empty), 36'd1);
    fill_to(3);
    chk("R10 ae 3", 36'(alm_empty), 36'd0);
    fill_to(53);
    chk("R10 af 53", 36'(alm_full), 36'd0);
    fill_to(54);
    chk("R10 af 54", 36'(alm_full), 36'd1);
  endtask

  task automatic t_retransmit();
    do_mrst(1'b0, 3'd0);
    fill_to(5);
    rd_std("R12 first pass");
    rd_std("R12 first pass");
    rd_std("R12 first pass");
    rt = 1'b1; wr_en = 1'b1; din = 36'hDEAD; rd_en = 1'b1;
    tick();
    rt = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    q.delete();
    foreach (hist[i]) q.push_back(hist[i]);
    chk("R12 replay avail", 36'(avail), 36'd1);
    while (q.size() > 0) rd_std("R12 replay");
    chk("R12 write ignored", 36'(avail), 36'd0);
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_std_flags();
    t_defaults();
    t_fwft();
    t_parallel();
    t_serial();
    t_retransmit();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule